// File: doc/BRIEF.md
# Dual-Channel UART Interrupt Status Aggregator

This block merges the interrupt requests of two UART channels and of three device-wide sources into one 32-bit read-only status word. A host can find out which channel needs service, and why, with a single access. Each channel supplies four request levels: line status, receive data, transmitter empty and modem status. The device-wide sources are a timer, a multipurpose I/O block and a wake-from-sleep detector. They have no field of their own. They are folded into channel 0's source code and its summary flag.

The request inputs are registered once. The status word is formed from those registers, so it reflects the inputs one clock later. A wake-up event stays pending until the host reads the low byte of the word. The wake-up detector only fires when the device leaves sleep after both channels had been asleep together.

Top module: `uart_irq_aggregator`

## Requirements
- R1: After a synchronous reset, every bit of `status_word` is 0.
- R2: Bit 0 is 1 exactly when channel 0 has any request pending, including a pending device-wide source. Bit 1 is 1 exactly when channel 1 has any channel request pending.
- R3: Each channel's 3-bit source code uses these values: 0 = none, 1 = line status, 2 = receive data, 3 = transmitter empty, 4 = modem status, 5 = multipurpose I/O, 6 = timer, 7 = wake-up.
- R4: When several sources of one channel are active, that channel's code is the smallest active code value.
- R5: Channel 0's code is at bits [10:8] and channel 1's code is at bits [13:11]. Bits [7:2] and [31:14] always read 0.
- R6: The timer, multipurpose I/O and wake-up sources appear only in channel 0's code and summary flag. Channel 1's code never exceeds 4.
- R7: The wake-up source becomes pending on the clock at which `ch_sleep` stops being all ones, provided it was all ones at the previous clock. Leaving sleep when only one channel had been asleep raises nothing.
- R8: A pending wake-up clears on the clock that samples `rd_en`=1 with `rd_be[0]`=1. A read with `rd_be[0]`=0 leaves it pending. Without a clearing read it stays pending.
- R9: If a new wake-up event and a clearing read are sampled on the same clock, the wake-up stays pending.
- R10: A change on any request input appears in `status_word` one clock after the edge that samples it, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_lsr_req | input | 2 | Line status request, one bit per channel |
| ch_rxd_req | input | 2 | Receive data request, one bit per channel |
| ch_txe_req | input | 2 | Transmitter empty request, one bit per channel |
| ch_msr_req | input | 2 | Modem status request, one bit per channel |
| tmr_req | input | 1 | Timer request level |
| mpio_req | input | 1 | Multipurpose I/O request level |
| ch_sleep | input | 2 | Sleep state, one bit per channel |
| rd_en | input | 1 | Host read strobe |
| rd_be | input | 4 | Byte enables of the host read |
| status_word | output | 32 | Aggregated interrupt status |

## Verification
Several corner cases are driven on purpose:
- **Priority.** Sources of one channel are made to collide, including a device-wide source together with a channel source. A wrong order would report the lower-priority code.
- **Sleep entry.** One channel is taken out of sleep after only it had slept. A detector that looked at a single channel would then raise a false wake-up.
- **Wake clearing.** Reads are issued with byte 0 disabled and then enabled, and the clearing read is made to coincide with a fresh wake event. A design that cleared on any read, or that let the clear win, would lose the pending wake-up.
- **Timing.** The output is sampled just before each edge. This catches a combinational path from the inputs that bypasses the register stage.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_CH   = 2;
    localparam int CODE_W   = 3;
    localparam int N_SRC    = 7;
    localparam int CODE_LSB = 8;
    localparam int WORD_W   = 32;

    typedef enum logic [CODE_W-1:0] {
        SRC_NONE = 3'd0,
        SRC_LSR  = 3'd1,
        SRC_RXD  = 3'd2,
        SRC_TXE  = 3'd3,
        SRC_MSR  = 3'd4,
        SRC_MPIO = 3'd5,
        SRC_TMR  = 3'd6,
        SRC_WAKE = 3'd7
    } irq_code_e;

    typedef struct packed {
        logic modem;
        logic txe;
        logic rxd;
        logic lsr;
    } chan_req_t;

    typedef struct packed {
        logic wake;
        logic timer;
        logic mpio;
    } dev_req_t;

    function automatic irq_code_e pick_code(input logic [N_SRC-1:0] v);
        irq_code_e c;
        c = SRC_NONE;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (v[i]) c = irq_code_e'(3'(i + 1));
        end
        return c;
    endfunction

endpackage

// File: rtl/irq_src_encoder.sv
module irq_src_encoder
    import uart_irq_pkg::*;
#(
    parameter bit HAS_DEV = 1'b0
) (
    input  chan_req_t req,
    input  dev_req_t  dev,
    output irq_code_e code,
    output logic      pending
);
    logic [N_SRC-1:0] vec;

    generate
        if (HAS_DEV) begin : g_dev
            assign vec = {dev, req};
        end else begin : g_nodev
            assign vec = {3'b000, req};
        end
    endgenerate

    assign code    = pick_code(vec);
    assign pending = |vec;

endmodule

// File: rtl/irq_wake_tracker.sv
module irq_wake_tracker
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ch_sleep,
    input  logic              rd_en,
    input  logic [3:0]        rd_be,
    output logic              wake_pend
);
    logic all_asleep_q;
    logic wake_evt;
    logic clr;

    assign wake_evt = all_asleep_q & ~(&ch_sleep);
    assign clr      = rd_en & rd_be[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            all_asleep_q <= 1'b0;
            wake_pend    <= 1'b0;
        end else begin
            all_asleep_q <= &ch_sleep;
            wake_pend    <= wake_evt | (wake_pend & ~clr);
        end
    end

    assert_wake_origin_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_pend) |-> $past(all_asleep_q));

    assert_wake_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_be[0] && !(all_asleep_q && !(&ch_sleep))) |=> !wake_pend);

    assert_wake_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (wake_pend && !(rd_en && rd_be[0])) |=> wake_pend);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (all_asleep_q && !(&ch_sleep)) |=> wake_pend);

endmodule

// File: rtl/uart_irq_aggregator.sv
module uart_irq_aggregator
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ch_lsr_req,
    input  logic [NUM_CH-1:0] ch_rxd_req,
    input  logic [NUM_CH-1:0] ch_txe_req,
    input  logic [NUM_CH-1:0] ch_msr_req,
    input  logic              tmr_req,
    input  logic              mpio_req,
    input  logic [NUM_CH-1:0] ch_sleep,
    input  logic              rd_en,
    input  logic [3:0]        rd_be,
    output logic [WORD_W-1:0] status_word
);
    localparam int CH1_LSB = CODE_LSB + CODE_W;
    localparam int FLD_MSB = CODE_LSB + NUM_CH * CODE_W - 1;

    chan_req_t          req_q [NUM_CH];
    logic               tmr_q;
    logic               mpio_q;
    logic               wake_pend;
    irq_code_e          code  [NUM_CH];
    logic [NUM_CH-1:0]  pend;
    dev_req_t           dev_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CH; c++) req_q[c] <= '0;
            tmr_q  <= 1'b0;
            mpio_q <= 1'b0;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                req_q[c].lsr   <= ch_lsr_req[c];
                req_q[c].rxd   <= ch_rxd_req[c];
                req_q[c].txe   <= ch_txe_req[c];
                req_q[c].modem <= ch_msr_req[c];
            end
            tmr_q  <= tmr_req;
            mpio_q <= mpio_req;
        end
    end

    irq_wake_tracker u_wake (
        .clk       (clk),
        .rst       (rst),
        .ch_sleep  (ch_sleep),
        .rd_en     (rd_en),
        .rd_be     (rd_be),
        .wake_pend (wake_pend)
    );

    always_comb begin
        dev_r.wake  = wake_pend;
        dev_r.timer = tmr_q;
        dev_r.mpio  = mpio_q;
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            irq_src_encoder #(.HAS_DEV(c == 0)) u_enc (
                .req     (req_q[c]),
                .dev     (dev_r),
                .code    (code[c]),
                .pending (pend[c])
            );
        end
    endgenerate

    always_comb begin
        status_word = '0;
        status_word[NUM_CH-1:0] = pend;
        for (int c = 0; c < NUM_CH; c++) begin
            status_word[CODE_LSB + c*CODE_W +: CODE_W] = code[c];
        end
    end

    assert_summary_code_R2: assert property (@(posedge clk) disable iff (rst)
        status_word[0] == (status_word[CODE_LSB +: CODE_W] != 3'd0));

    assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (rst)
        status_word[CODE_LSB-1:NUM_CH] == '0 && status_word[WORD_W-1:FLD_MSB+1] == '0);

    assert_ch1_range_R6: assert property (@(posedge clk) disable iff (rst)
        status_word[CH1_LSB +: CODE_W] <= 3'd4);

    assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(ch_lsr_req[1]) && !$past(rst)) |-> status_word[CH1_LSB +: CODE_W] == 3'd1);

endmodule

// File: tb/sim_uart_irq_aggregator.sv
`timescale 1ns/1ps
module sim_uart_irq_aggregator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  lsr = '0, rxd = '0, txe = '0, msr = '0, slp = '0;
    logic        tmr = 1'b0, mpio = 1'b0, rd = 1'b0;
    logic [3:0]  be = '0;
    logic [31:0] sw;

    int checks = 0;
    int errors = 0;

    logic [31:0] q_exp [$];
    string       q_tag [$];
    logic [31:0] prev_exp = '0;
    logic        m_prev = 1'b0, m_wake = 1'b0;

    always #2 clk = ~clk;

    uart_irq_aggregator u0 (
        .clk(clk), .rst(rst),
        .ch_lsr_req(lsr), .ch_rxd_req(rxd), .ch_txe_req(txe), .ch_msr_req(msr),
        .tmr_req(tmr), .mpio_req(mpio), .ch_sleep(slp),
        .rd_en(rd), .rd_be(be), .status_word(sw)
    );

    function automatic logic [2:0] lowest(input logic [6:0] v);
        for (int i = 0; i < 7; i++) if (v[i]) return 3'(i + 1);
        return 3'd0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input string tag);
        logic [31:0] e;
        logic [6:0]  v0, v1;
        logic        evt;
        #1;
        check({tag, " R10 before edge"}, sw, prev_exp);
        evt    = m_prev & ~(&slp);
        m_wake = evt | (m_wake & ~(rd & be[0]));
        m_prev = &slp;
        v0 = {m_wake, tmr, mpio, msr[0], txe[0], rxd[0], lsr[0]};
        v1 = {3'b000, msr[1], txe[1], rxd[1], lsr[1]};
        e = '0;
        e[0] = |v0;
        e[1] = |v1;
        e[10:8]  = lowest(v0);
        e[13:11] = lowest(v1);
        q_exp.push_back(e);
        q_tag.push_back(tag);
        prev_exp = e;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        #1;
        if (q_exp.size() > 0) check(q_tag.pop_front(), sw, q_exp.pop_front());
    end

    task automatic idle();
        lsr = '0; rxd = '0; txe = '0; msr = '0; tmr = 0; mpio = 0; rd = 0; be = '0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", sw, 32'h0);
        rst = 0;

        lsr = 2'b01; drive("R3 ch0 line status");
        idle(); rxd = 2'b01; drive("R3 ch0 rx");
        idle(); txe = 2'b01; drive("R3 ch0 tx empty");
        idle(); msr = 2'b01; drive("R3 ch0 modem R2");
        idle(); lsr = 2'b10; drive("R5 ch1 line status");
        idle(); txe = 2'b10; drive("R5 ch1 tx R2");
        idle(); msr = 2'b10; rxd = 2'b01; drive("R5 both channels");
        idle(); drive("R2 idle");

        lsr = 2'b11; rxd = 2'b11; txe = 2'b11; msr = 2'b11; drive("R4 all sources");
        idle(); msr = 2'b01; txe = 2'b01; drive("R4 modem+tx");
        idle(); msr = 2'b10; rxd = 2'b10; drive("R4 ch1 modem+rx");

        idle(); tmr = 1; drive("R6 timer only");
        idle(); tmr = 1; mpio = 1; drive("R6 mpio over timer");
        idle(); tmr = 1; rxd = 2'b01; drive("R6 rx over timer");
        idle(); tmr = 1; mpio = 1; txe = 2'b10; drive("R6 ch1 unaffected");
        idle(); drive("R6 idle");

        slp = 2'b01; drive("R7 ch0 asleep");
        slp = 2'b00; drive("R7 single wake none");
        slp = 2'b11; drive("R7 both asleep");
        slp = 2'b11; drive("R7 still asleep");
        slp = 2'b10; drive("R7 wake raised");
        drive("R8 stays pending");
        msr = 2'b01; drive("R8 wake under modem");
        idle(); rd = 1; be = 4'b1110; drive("R8 read no byte0");
        idle(); drive("R8 still pending");
        rd = 1; be = 4'b0001; drive("R8 clearing read");
        idle(); drive("R8 cleared");

        slp = 2'b11; drive("R9 asleep");
        slp = 2'b00; rd = 1; be = 4'b1111; drive("R9 set wins");
        idle(); drive("R9 pending");
        rd = 1; be = 4'b0001; drive("R9 clear after");
        idle(); lsr = 2'b10; drive("R10 ch1 step");
        idle(); drive("R10 drop");

        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule